// File: doc/BRIEF.md
# Programmable Divided Clock Generator

This block produces a set of derived clocks from a bank of source clocks, all programmed through a small word-addressed register port. Each output channel selects one source, may invert it on the way in, divides it by a ratio from 1 to 256, and may then bypass the divider and invert the final result. A shared control word holds the divider enable, the per-channel input inversion bits and two clock-gating modes: one for the bus clock and one for the peripheral clock.

Source clocks are modelled as level signals that are sampled in the register clock domain. The divider advances on each rising edge of the selected, possibly inverted, source. Every channel output is a registered level in that same domain. Glitch-free source switching is not provided. After a reconfiguration, each channel restarts its period cleanly at the next source edge.

Register map: channel n sits at word address 2·n, the control word sits at word address 2·NUM_CH, and every other address reads as zero.

Top module: `clkgen_top`

## Requirements
- R1: After reset, every register reads zero, every `clk_o` bit is 0, and both `bus_clk_en_o` and `pclk_en_o` are 0 while `bus_busy_i` is 0.
- R2: A read (`req_i`=1, `we_i`=0) returns the addressed word on `rdata_o` one cycle later. A channel word keeps bits [12:0] and a control word keeps bits [3+NUM_CH:0]; all other bits read 0. Odd addresses and addresses above the control word read 0, and writes to them are ignored.
- R3: Control bits [1:0] hold the bus clock mode, encoded as 0=off, 2=dynamic, 3=on. Writing 1 stores 0. `bus_clk_en_o` is 0 when the mode is off, equals `bus_busy_i` when the mode is dynamic, and is 1 when the mode is on.
- R4: Control bit 3 holds the peripheral clock mode. When it is 0, `pclk_en_o` equals `bus_busy_i`; when it is 1, `pclk_en_o` is 1.
- R5: Channel bits [12:5] hold the ratio minus one (R = field+1). For R≥2, the output is high for ceil(R/2) and low for floor(R/2) periods of the selected source. For R=1, the output follows the source.
- R6: Channel bits [4:2] pick which `src_i` bit the channel uses.
- R7: Control bit 4+n inverts the selected source of channel n before the divider and before the bypass path.
- R8: Channel bit 1 inverts the channel's final output.
- R9: Channel bit 0 bypasses the divider. `clk_o[n]` then equals the selected, input-inverted, output-inverted source as sampled one cycle earlier, whatever the value of control bit 2.
- R10: While control bit 2 (divider enable) is 0, the divider stage is held low, so a non-bypassed `clk_o[n]` equals channel bit 1. After the enable is set, the first source rising edge starts a high phase.
- R11: A write that changes a channel's ratio or source makes that channel begin a new period (high phase) at the next source rising edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid one cycle after a read |
| src_i | input | NUM_SRC | Source clock levels |
| bus_busy_i | input | 1 | Bus activity indication for dynamic gating |
| clk_o | output | NUM_CH | Generated channel clocks |
| bus_clk_en_o | output | 1 | Bus clock enable |
| pclk_en_o | output | 1 | Peripheral clock enable |

## Verification
The two functions that can land in the same cycle are a configuration write that changes a channel's ratio and a rising edge of that channel's selected source. In that case the edge is processed under the old settings, and the restart takes effect on the following edge. The bench provokes this by placing the write at every offset within the source period during a long low phase. It judges each offset by requiring the output to rise within one source period plus pipeline latency, where a channel that failed to restart would stay low for many more periods.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  localparam int DIV_W    = 8;
  localparam int SEL_W    = 3;
  localparam int SEL_LSB  = 2;
  localparam int DIV_LSB  = SEL_LSB + SEL_W;
  localparam int CH_BITS  = DIV_LSB + DIV_W;
  localparam int EN_BIT   = 2;
  localparam int PM_BIT   = 3;
  localparam int IINV_LSB = 4;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [SEL_W-1:0] sel;
    logic             out_inv;
    logic             bypass;
  } ch_cfg_t;

  localparam logic [1:0] BCLK_OFF = 2'd0;
  localparam logic [1:0] BCLK_DYN = 2'd2;
  localparam logic [1:0] BCLK_ON  = 2'd3;
endpackage

// File: rtl/clkgen_regs.sv
module clkgen_regs
  import clkgen_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [DATA_W-1:0]       rdata_o,
  output ch_cfg_t [NUM_CH-1:0]    cfg_o,
  output logic [NUM_CH-1:0]       cfg_wr_o,
  output logic [1:0]              bclk_mode_o,
  output logic                    pclk_on_o,
  output logic                    div_en_o,
  output logic [NUM_CH-1:0]       in_inv_o
);
  localparam int CTRL_ADDR = 2 * NUM_CH;

  ch_cfg_t [NUM_CH-1:0] cfg_q;
  logic [1:0]           bclk_q;
  logic                 pm_q, en_q;
  logic [NUM_CH-1:0]    iinv_q;
  logic [DATA_W-1:0]    rdata_q, rd_word;
  logic                 wr, rd, wr_ctrl;
  ch_cfg_t              wcfg;

  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign wr_ctrl = wr && (addr_i == ADDR_W'(CTRL_ADDR));
  assign wcfg    = ch_cfg_t'(wdata_i[CH_BITS-1:0]);

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      cfg_wr_o[i] = wr && (addr_i == ADDR_W'(2 * i)) &&
                    ((wcfg.div != cfg_q[i].div) || (wcfg.sel != cfg_q[i].sel));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (wr && (addr_i == ADDR_W'(2 * i))) cfg_q[i] <= wcfg;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q <= BCLK_OFF;
      en_q   <= 1'b0;
      pm_q   <= 1'b0;
      iinv_q <= '0;
    end else if (wr_ctrl) begin
      // encoding 1 is not a valid mode; it collapses to off
      bclk_q <= (wdata_i[1:0] == 2'b01) ? BCLK_OFF : wdata_i[1:0];
      en_q   <= wdata_i[EN_BIT];
      pm_q   <= wdata_i[PM_BIT];
      iinv_q <= wdata_i[IINV_LSB +: NUM_CH];
    end
  end

  always_comb begin
    rd_word = '0;
    if (addr_i == ADDR_W'(CTRL_ADDR)) begin
      rd_word[1:0]                = bclk_q;
      rd_word[EN_BIT]             = en_q;
      rd_word[PM_BIT]             = pm_q;
      rd_word[IINV_LSB +: NUM_CH] = iinv_q;
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr_i == ADDR_W'(2 * i)) rd_word[CH_BITS-1:0] = cfg_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_word;
  end

  assign rdata_o     = rdata_q;
  assign cfg_o       = cfg_q;
  assign bclk_mode_o = bclk_q;
  assign pclk_on_o   = pm_q;
  assign div_en_o    = en_q;
  assign in_inv_o    = iinv_q;
endmodule

// File: rtl/clkgen_chan.sv
module clkgen_chan
  import clkgen_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  ch_cfg_t            cfg_i,
  input  logic               en_i,
  input  logic               in_inv_i,
  input  logic               restart_i,
  output logic               div_lvl_o,
  output logic               clk_o
);
  localparam int NSEL = 1 << SEL_W;

  logic [NSEL-1:0]  src_pad;
  logic             sel_lvl, prev_q, rise;
  logic [DIV_W-1:0] cnt_q, nxt;
  logic [DIV_W:0]   hi_len;
  logic             div_q, pend_q, out_q;

  always_comb begin
    src_pad = '0;
    src_pad[NUM_SRC-1:0] = src_i;
  end

  assign sel_lvl = src_pad[cfg_i.sel] ^ in_inv_i;
  assign rise    = sel_lvl & ~prev_q;
  assign hi_len  = ({1'b0, cfg_i.div} + (DIV_W+1)'(2)) >> 1;
  assign nxt     = (pend_q || (cnt_q == cfg_i.div)) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sel_lvl;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      div_q  <= 1'b0;
      pend_q <= 1'b1;
    end else if (!en_i) begin
      cnt_q  <= '0;
      div_q  <= 1'b0;
      pend_q <= 1'b1;
    end else if (cfg_i.div == '0) begin
      div_q  <= sel_lvl;
      pend_q <= restart_i | (pend_q & ~rise);
    end else begin
      if (rise) begin
        cnt_q <= nxt;
        div_q <= ({1'b0, nxt} < hi_len);
      end
      // an edge in the write cycle uses old settings; restart on the next one
      pend_q <= restart_i | (pend_q & ~rise);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= (cfg_i.bypass ? sel_lvl : div_q) ^ cfg_i.out_inv;
  end

  assign div_lvl_o = div_q;
  assign clk_o     = out_q;
endmodule

// File: rtl/clkgen_top.sv
module clkgen_top
  import clkgen_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = $clog2(2 * NUM_CH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_busy_i,
  output logic [NUM_CH-1:0]  clk_o,
  output logic               bus_clk_en_o,
  output logic               pclk_en_o
);
  ch_cfg_t [NUM_CH-1:0] cfg_w;
  logic [NUM_CH-1:0]    cfg_wr_w, in_inv_w, div_lvl_w;
  logic [1:0]           bclk_w;
  logic                 pclk_on_w, div_en_w;

  clkgen_regs #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .cfg_o       (cfg_w),
    .cfg_wr_o    (cfg_wr_w),
    .bclk_mode_o (bclk_w),
    .pclk_on_o   (pclk_on_w),
    .div_en_o    (div_en_w),
    .in_inv_o    (in_inv_w)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    clkgen_chan #(
      .NUM_SRC (NUM_SRC)
    ) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .src_i     (src_i),
      .cfg_i     (cfg_w[g]),
      .en_i      (div_en_w),
      .in_inv_i  (in_inv_w[g]),
      .restart_i (cfg_wr_w[g]),
      .div_lvl_o (div_lvl_w[g]),
      .clk_o     (clk_o[g])
    );
  end

  assign bus_clk_en_o = (bclk_w == BCLK_ON) | ((bclk_w == BCLK_DYN) & bus_busy_i);
  assign pclk_en_o    = pclk_on_w | bus_busy_i;
endmodule

// File: rtl/clkgen_chk.sv
module clkgen_chk
  import clkgen_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_SRC-1:0]   src_i,
  input logic [DATA_W-1:0]    rdata_o,
  input logic [NUM_CH-1:0]    clk_o,
  input logic                 bus_clk_en_o,
  input logic                 pclk_en_o,
  input ch_cfg_t [NUM_CH-1:0] cfg_w,
  input logic [NUM_CH-1:0]    in_inv_w,
  input logic [NUM_CH-1:0]    div_lvl_w,
  input logic [1:0]           bclk_w,
  input logic                 pclk_on_w,
  input logic                 div_en_w
);
  localparam int NSEL = 1 << SEL_W;
  logic [NSEL-1:0] src_pad;

  always_comb begin
    src_pad = '0;
    src_pad[NUM_SRC-1:0] = src_i;
  end

  a_r2_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:CH_BITS] == '0);

  a_r3_no_mode1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bclk_w != 2'b01);

  a_r3_off_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bclk_w == BCLK_OFF) |-> !bus_clk_en_o);

  a_r4_pclk_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pclk_on_w |-> pclk_en_o);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    a_r10_div_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !div_en_w |=> !div_lvl_w[g]);

    a_r9_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_w[g].bypass |=>
        clk_o[g] == $past(src_pad[cfg_w[g].sel] ^ in_inv_w[g] ^ cfg_w[g].out_inv));
  end
endmodule

bind clkgen_top clkgen_chk #(
  .NUM_CH  (NUM_CH),
  .NUM_SRC (NUM_SRC),
  .DATA_W  (DATA_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .src_i        (src_i),
  .rdata_o      (rdata_o),
  .clk_o        (clk_o),
  .bus_clk_en_o (bus_clk_en_o),
  .pclk_en_o    (pclk_en_o),
  .cfg_w        (cfg_w),
  .in_inv_w     (in_inv_w),
  .div_lvl_w    (div_lvl_w),
  .bclk_w       (bclk_w),
  .pclk_on_w    (pclk_on_w),
  .div_en_w     (div_en_w)
);

// File: tb/sim_clkgen_top.sv
module sim_clkgen_top;
  localparam int CLK_P   = 10;
  localparam int NUM_CH  = 2;
  localparam int NUM_SRC = 8;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 3;
  localparam int CTRL_A  = 2 * NUM_CH;
  localparam int LIM     = 4000;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               req = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0]  addr = '0;
  logic [DATA_W-1:0]  wdata = '0;
  logic [DATA_W-1:0]  rdata;
  logic [NUM_SRC-1:0] src = '0;
  logic               busy = 1'b0;
  logic [NUM_CH-1:0]  clk_out;
  logic               bus_en, pclk_en;
  int                 n_chk = 0, n_fail = 0;
  int                 ph [NUM_SRC];

  always #(CLK_P/2) clk = ~clk;

  clkgen_top u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_i        (req),
    .we_i         (we),
    .addr_i       (addr),
    .wdata_i      (wdata),
    .rdata_o      (rdata),
    .src_i        (src),
    .bus_busy_i   (busy),
    .clk_o        (clk_out),
    .bus_clk_en_o (bus_en),
    .pclk_en_o    (pclk_en)
  );

  // source k toggles every k+1 cycles: period 2*(k+1)
  initial begin
    for (int k = 0; k < NUM_SRC; k++) ph[k] = 0;
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      for (int k = 0; k < NUM_SRC; k++) begin
        if (ph[k] == k) begin src[k] = ~src[k]; ph[k] = 0; end
        else ph[k] = ph[k] + 1;
      end
    end
  end

  function automatic void chk(bit ok, string req_tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endfunction

  function automatic logic [31:0] chw(int r, int sel, bit oi, bit byp);
    return {19'd0, 8'(r - 1), 3'(sel), oi, byp};
  endfunction

  function automatic logic [31:0] ctw(int bm, bit en, bit pm, int iinv);
    return {26'd0, 2'(iinv), pm, en, 2'(bm)};
  endfunction

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = ADDR_W'(a);
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic measure(int ch, output int hi, output int lo);
    int t = 0;
    hi = 0; lo = 0;
    while (clk_out[ch] !== 1'b0 && t < LIM) begin @(negedge clk); t++; end
    while (clk_out[ch] !== 1'b1 && t < LIM) begin @(negedge clk); t++; end
    while (clk_out[ch] === 1'b1 && t < LIM) begin hi++; @(negedge clk); t++; end
    while (clk_out[ch] === 1'b0 && t < LIM) begin lo++; @(negedge clk); t++; end
    if (t >= LIM) begin hi = -1; lo = -1; end
  endtask

  task automatic cycles_to_high(int ch, output int t);
    t = 0;
    while (clk_out[ch] !== 1'b1 && t < LIM) begin @(negedge clk); t++; end
  endtask

  initial begin
    #(CLK_P * 190000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int hi, lo, t, r, ehi, elo;
    int ratios [10] = '{1, 2, 3, 4, 5, 7, 8, 16, 255, 256};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(clk_out == '0, "R1 clk_o", clk_out, 0);
    chk(!bus_en && !pclk_en, "R1 enables", {bus_en, pclk_en}, 0);
    for (int a = 0; a < 8; a++) begin
      rd(a, d);
      chk(d == 0, "R1 reg", d, 0);
    end

    // R2 readback masks and holes
    wr(0, 32'hFFFF_FFFF); rd(0, d); chk(d == 32'h1FFF, "R2 ch0 mask", d, 32'h1FFF);
    wr(2, 32'hFFFF_EAA5); rd(2, d); chk(d == 32'h0AA5, "R2 ch1 mask", d, 32'h0AA5);
    wr(1, 32'hFFFF_FFFF); rd(1, d); chk(d == 0, "R2 odd addr", d, 0);
    rd(0, d); chk(d == 32'h1FFF, "R2 ch0 untouched", d, 32'h1FFF);
    wr(CTRL_A, 32'hFFFF_FFFF); rd(CTRL_A, d); chk(d == 32'h3F, "R2 ctrl mask", d, 32'h3F);
    for (int a = CTRL_A + 1; a < 8; a++) begin
      wr(a, 32'hFFFF_FFFF); rd(a, d); chk(d == 0, "R2 high addr", d, 0);
    end

    // R3 bus clock mode, R4 peripheral clock mode
    wr(CTRL_A, ctw(1, 0, 0, 0)); rd(CTRL_A, d);
    chk(d[1:0] == 0, "R3 mode1 reads off", d[1:0], 0);
    for (int m = 0; m < 4; m++) begin
      wr(CTRL_A, ctw(m, 0, m[0], 0));
      for (int b = 0; b < 2; b++) begin
        busy = b[0];
        @(negedge clk);
        chk(bus_en == ((m == 3) || (m == 2 && b == 1)), "R3 bus_clk_en", bus_en,
            (m == 3) || (m == 2 && b == 1));
        chk(pclk_en == (m[0] || b[0]), "R4 pclk_en", pclk_en, m[0] || b[0]);
      end
    end
    busy = 1'b0;

    // R5 R8 ratio sweep on source 1 (period 4), both channels
    wr(CTRL_A, ctw(0, 1, 0, 0));
    for (int ch = 0; ch < NUM_CH; ch++) begin
      for (int i = 0; i < 10; i++) begin
        bit oi = i[0];
        r = ratios[i];
        wr(2 * ch, chw(r, 1, oi, 0));
        repeat (3) @(negedge clk);
        measure(ch, hi, lo);
        if (r == 1) begin ehi = 2; elo = 2; end
        else begin ehi = ((r + 1) / 2) * 4; elo = (r / 2) * 4; end
        if (oi) begin t = ehi; ehi = elo; elo = t; end
        chk(hi == ehi, oi ? "R8 R5 high" : "R5 high", hi, ehi);
        chk(lo == elo, oi ? "R8 R5 low" : "R5 low", lo, elo);
      end
    end

    // R6 source sweep, ratio 3
    for (int k = 0; k < NUM_SRC; k++) begin
      int ch = k % NUM_CH;
      wr(2 * ch, chw(3, k, 0, 0));
      repeat (3) @(negedge clk);
      measure(ch, hi, lo);
      chk(hi == 4 * (k + 1), "R6 src high", hi, 4 * (k + 1));
      chk(lo == 2 * (k + 1), "R6 src low", lo, 2 * (k + 1));
    end

    // R7 R8 R9 bypass levels with inversions, divider disabled
    for (int en = 0; en < 2; en++) begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        for (int v = 0; v < 8; v++) begin
          bit ii = v[0], oi = v[1];
          int sel = v[2] ? 5 : 0;
          logic prev;
          bit ok = 1'b1;
          logic got = 1'b0, exp = 1'b0;
          wr(CTRL_A, ctw(0, en[0], 0, ii ? (1 << ch) : 0));
          wr(2 * ch, chw(2, sel, oi, 1));
          repeat (2) @(negedge clk);
          prev = src[sel];
          repeat (24) begin
            @(negedge clk);
            if (ok && clk_out[ch] !== (prev ^ ii ^ oi)) begin
              ok = 1'b0; got = clk_out[ch]; exp = prev ^ ii ^ oi;
            end
            prev = src[sel];
          end
          chk(ok, ii ? "R7 R9 bypass inv" : "R9 bypass", got, exp);
        end
      end
    end

    // R7 input inversion keeps divided duty
    wr(CTRL_A, ctw(0, 1, 0, 2));
    wr(2, chw(3, 2, 0, 0));
    repeat (3) @(negedge clk);
    measure(1, hi, lo);
    chk(hi == 12 && lo == 6, "R7 divided inv", {hi, lo}, {32'd12, 32'd6});

    // R10 divider disabled holds output at out_inv
    for (int o = 0; o < 2; o++) begin
      bit ok = 1'b1;
      wr(CTRL_A, ctw(0, 0, 0, 0));
      wr(0, chw(4, 0, o[0], 0));
      repeat (3) @(negedge clk);
      repeat (30) begin
        @(negedge clk);
        if (clk_out[0] !== o[0]) ok = 1'b0;
      end
      chk(ok, "R10 held", clk_out[0], o);
    end
    wr(0, chw(16, 1, 0, 0));
    repeat (5) @(negedge clk);
    wr(CTRL_A, ctw(0, 1, 0, 0));
    cycles_to_high(0, t);
    chk(t <= 7, "R10 enable start", t, 7);

    // R11 restart on ratio change, write swept across source period
    for (int off = 0; off < 4; off++) begin
      int k = 0;
      while (clk_out[0] !== 1'b1 && k < LIM) begin @(negedge clk); k++; end
      while (clk_out[0] !== 1'b0 && k < LIM) begin @(negedge clk); k++; end
      repeat (2 + off) @(negedge clk);
      wr(0, chw(off[0] ? 16 : 15, 1, 0, 0));
      cycles_to_high(0, t);
      chk(t <= 6, "R11 restart", t, 6);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule